// File: doc/BRIEF.md
# Load/Store Register-Operand Constraint Checker

This block sits in the decode stage, beside the register-offset load/store path. Each case it receives carries the four register indices already pulled from the instruction: the data register, the second data register, the base register and the offset register. It also carries the access size, the load/store direction, the indexing form (plain offset, pre-indexed or post-indexed), the instruction-set mode (full-width, compact 32-bit or compact 16-bit) and a legacy-architecture flag. From these it reports whether the operand combination is legal, deprecated or unpredictable.

The rules cover five areas: base/data/offset overlap under writeback, even/odd pairing for the two-register (dual) access, the reach of the 16-bit encoding into the low registers, and the special treatment of the program counter and the stack pointer. A small output register with a valid/ready handshake lets a stream of cases pass through at one per cycle.

Field encodings. Size: 0 word, 1 unsigned byte, 2 signed byte, 3 unsigned half, 4 signed half, 5 dual. Index form: 0 plain offset, and any non-zero value means writeback (1 pre-indexed, 2 post-indexed). Mode: 0 full-width, 1 compact 32-bit, 2 compact 16-bit; every mode other than 0 counts as compact. The special register indices are SP = 13, link register = 14 and PC = 15.

Top module: `lsc_operand_checker`

## Requirements
- R1: An offset register equal to PC (15) is illegal.
- R2: In compact 16-bit mode, any of data, base or offset register above r7 is illegal, and so is a dual access.
- R3: A full-mode dual access is illegal if the data register is odd, if it is the link register (14), or if the second register is not the data register plus one.
- R4: A compact-mode dual access is illegal if either data register is SP (13) or PC (15).
- R5: These cases are unpredictable: a writeback form whose base equals the data register, and, with the legacy flag set, a writeback form whose base equals the offset register.
- R6: These cases are unpredictable: a dual load whose offset register equals either data register, and a dual writeback access whose base equals the second data register.
- R7: The PC rules depend on the mode.
  - Full mode: PC as the data register is illegal unless the access is a word, and PC as the base is illegal in writeback forms. For stores, PC as the data register or as a plain-offset base is deprecated.
  - Compact mode: PC as the data register is legal only for a word load, and PC as the base is illegal.
- R8: SP as the offset register, or as the data register of a non-word access, is unpredictable in compact mode and deprecated in full mode.
- R9: A full-mode dual access with r12 as the data register is deprecated and not an error.
- R10: legal is 1 exactly when no illegal or unpredictable rule fires. deprecated is reported only together with legal. unpredictable is 1 whenever an unpredictable rule fires.
- R11: in_ready equals !out_valid || out_ready. An accepted case appears on the outputs in the next cycle, and the outputs stay stable while out_valid is high and out_ready is low.
- R12: After reset, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Case offered |
| in_ready | output | 1 | Case can be taken this cycle |
| in_rt | input | 4 | Data register index |
| in_rt2 | input | 4 | Second data register index (dual only) |
| in_rn | input | 4 | Base register index |
| in_rm | input | 4 | Offset register index |
| in_size | input | 3 | Access size code |
| in_load | input | 1 | 1 = load, 0 = store |
| in_index | input | 2 | Indexing form code |
| in_isa | input | 2 | Instruction-set mode code |
| in_legacy | input | 1 | Legacy architecture level |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result |
| out_legal | output | 1 | Combination is legal |
| out_deprecated | output | 1 | Legal but deprecated |
| out_unpredictable | output | 1 | An unpredictable rule fired |

## Verification
Two things can happen in the same clock edge: a new case is accepted, and the held result is drained. The bench keeps in_valid asserted back to back while out_ready is asserted, so every such edge both replaces and consumes the register. On those edges the scoreboard must see each result exactly once and in order. A periodic low on out_ready creates stalls as well, and during each stall the bench confirms that the held flags do not change and that no further case is accepted.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
   typedef enum logic [2:0] {
      SZ_WORD  = 3'd0,
      SZ_UBYTE = 3'd1,
      SZ_SBYTE = 3'd2,
      SZ_UHALF = 3'd3,
      SZ_SHALF = 3'd4,
      SZ_DUAL  = 3'd5
   } lsc_size_e;

   typedef enum logic [1:0] {
      IX_OFFSET = 2'd0,
      IX_PRE    = 2'd1,
      IX_POST   = 2'd2
   } lsc_index_e;

   typedef enum logic [1:0] {
      ISA_FULL   = 2'd0,
      ISA_WIDE   = 2'd1,
      ISA_NARROW = 2'd2
   } lsc_isa_e;

   typedef struct packed {
      logic illegal;
      logic unpred;
      logic deprec;
   } lsc_hits_t;
endpackage

// File: rtl/lsc_pair_rules.sv
module lsc_pair_rules
   import lsc_pkg::*;
#(
   parameter int REG_W        = 4,
   parameter int SP_IDX       = 13,
   parameter int LR_IDX       = 14,
   parameter int PC_IDX       = 15,
   parameter int IP_IDX       = 12,
   parameter int LOW_REGS     = 8,
   parameter bit FLAG_IP_PAIR = 1'b1
) (
   input  logic [REG_W-1:0] rt,
   input  logic [REG_W-1:0] rt2,
   input  logic [REG_W-1:0] rn,
   input  logic [REG_W-1:0] rm,
   input  lsc_size_e        size,
   input  lsc_isa_e         isa,
   output lsc_hits_t        hits
);
   localparam logic [REG_W-1:0] SP_R  = REG_W'(SP_IDX);
   localparam logic [REG_W-1:0] LR_R  = REG_W'(LR_IDX);
   localparam logic [REG_W-1:0] PC_R  = REG_W'(PC_IDX);
   localparam logic [REG_W-1:0] IP_R  = REG_W'(IP_IDX);
   localparam logic [REG_W-1:0] LOW_R = REG_W'(LOW_REGS);

   logic dual, full, narrow;
   logic off_pc, narrow_range, full_pair_bad, wide_pair_bad, ip_pair;
   logic [REG_W:0] rt_next;

   assign dual    = (size == SZ_DUAL);
   assign full    = (isa == ISA_FULL);
   assign narrow  = (isa == ISA_NARROW);
   assign rt_next = {1'b0, rt} + 1'b1;

   // offset register can never be PC
   assign off_pc = (rm == PC_R);

   // 16-bit encoding reaches low registers only, and has no dual form
   assign narrow_range = narrow &&
                         ((rt >= LOW_R) || (rn >= LOW_R) || (rm >= LOW_R) || dual);

   // full-mode pairing: even first register, not link, consecutive second
   assign full_pair_bad = full && dual &&
                          (rt[0] || (rt == LR_R) || ({1'b0, rt2} != rt_next));

   // compact dual: neither register may be SP or PC
   assign wide_pair_bad = !full && dual &&
                          ((rt == SP_R) || (rt == PC_R) || (rt2 == SP_R) || (rt2 == PC_R));

   generate
      if (FLAG_IP_PAIR) begin : g_ip_flag
         assign ip_pair = full && dual && (rt == IP_R);
      end else begin : g_ip_quiet
         assign ip_pair = 1'b0;
      end
   endgenerate

   assign hits.illegal = off_pc || narrow_range || full_pair_bad || wide_pair_bad;
   assign hits.unpred  = 1'b0;
   assign hits.deprec  = ip_pair;
endmodule

// File: rtl/lsc_overlap_rules.sv
module lsc_overlap_rules
   import lsc_pkg::*;
#(
   parameter int REG_W = 4
) (
   input  logic [REG_W-1:0] rt,
   input  logic [REG_W-1:0] rt2,
   input  logic [REG_W-1:0] rn,
   input  logic [REG_W-1:0] rm,
   input  lsc_size_e        size,
   input  logic             load,
   input  lsc_index_e       index,
   input  logic             legacy,
   output lsc_hits_t        hits
);
   logic wb, dual;
   logic base_data, base_off, dual_off, dual_base;

   assign wb   = (index != IX_OFFSET);
   assign dual = (size == SZ_DUAL);

   assign base_data = wb && (rn == rt);
   assign base_off  = wb && legacy && (rn == rm);
   assign dual_off  = dual && load && ((rm == rt) || (rm == rt2));
   assign dual_base = dual && wb && (rn == rt2);

   assign hits.illegal = 1'b0;
   assign hits.unpred  = base_data || base_off || dual_off || dual_base;
   assign hits.deprec  = 1'b0;
endmodule

// File: rtl/lsc_pcsp_rules.sv
module lsc_pcsp_rules
   import lsc_pkg::*;
#(
   parameter int REG_W  = 4,
   parameter int SP_IDX = 13,
   parameter int PC_IDX = 15
) (
   input  logic [REG_W-1:0] rt,
   input  logic [REG_W-1:0] rn,
   input  logic [REG_W-1:0] rm,
   input  lsc_size_e        size,
   input  logic             load,
   input  lsc_index_e       index,
   input  lsc_isa_e         isa,
   output lsc_hits_t        hits
);
   localparam logic [REG_W-1:0] SP_R = REG_W'(SP_IDX);
   localparam logic [REG_W-1:0] PC_R = REG_W'(PC_IDX);

   logic wb, word, full;
   logic rt_pc, rn_pc, rm_sp, rt_sp_narrow;

   assign wb    = (index != IX_OFFSET);
   assign word  = (size == SZ_WORD);
   assign full  = (isa == ISA_FULL);
   assign rt_pc = (rt == PC_R);
   assign rn_pc = (rn == PC_R);
   assign rm_sp = (rm == SP_R);
   assign rt_sp_narrow = (rt == SP_R) && !word;

   always_comb begin
      hits = '0;
      if (full) begin
         hits.illegal = (rt_pc && !word) || (rn_pc && wb);
         hits.deprec  = (!load && rt_pc) || (!load && rn_pc && !wb) ||
                        rm_sp || rt_sp_narrow;
      end else begin
         hits.illegal = (rt_pc && !(load && word)) || rn_pc;
         hits.unpred  = rm_sp || rt_sp_narrow;
      end
   end
endmodule

// File: rtl/lsc_operand_checker.sv
module lsc_operand_checker
   import lsc_pkg::*;
#(
   parameter int REG_W        = 4,
   parameter int SP_IDX       = 13,
   parameter int LR_IDX       = 14,
   parameter int PC_IDX       = 15,
   parameter int IP_IDX       = 12,
   parameter int LOW_REGS     = 8,
   parameter bit FLAG_IP_PAIR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [REG_W-1:0] in_rt,
   input  logic [REG_W-1:0] in_rt2,
   input  logic [REG_W-1:0] in_rn,
   input  logic [REG_W-1:0] in_rm,
   input  logic [2:0]       in_size,
   input  logic             in_load,
   input  logic [1:0]       in_index,
   input  logic [1:0]       in_isa,
   input  logic             in_legacy,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             out_legal,
   output logic             out_deprecated,
   output logic             out_unpredictable
);
   localparam int REG_N = 1 << REG_W;

   generate
      if (REG_W < 4) begin : g_bad_width
         $error("REG_W must cover at least sixteen registers");
      end
      if (SP_IDX >= REG_N || LR_IDX >= REG_N || PC_IDX >= REG_N || IP_IDX >= REG_N) begin : g_bad_idx
         $error("special register index outside register file");
      end
      if (LOW_REGS < 1 || LOW_REGS > REG_N) begin : g_bad_low
         $error("LOW_REGS out of range");
      end
   endgenerate

   lsc_size_e  size_e;
   lsc_index_e index_e;
   lsc_isa_e   isa_e;
   lsc_hits_t  pair_h, ovl_h, pcsp_h;
   logic       any_ill, any_unp, any_dep, legal_c, accept;

   assign size_e  = lsc_size_e'(in_size);
   assign index_e = lsc_index_e'(in_index);
   assign isa_e   = lsc_isa_e'(in_isa);

   lsc_pair_rules #(
      .REG_W(REG_W), .SP_IDX(SP_IDX), .LR_IDX(LR_IDX), .PC_IDX(PC_IDX),
      .IP_IDX(IP_IDX), .LOW_REGS(LOW_REGS), .FLAG_IP_PAIR(FLAG_IP_PAIR)
   ) pair_i (
      .rt(in_rt), .rt2(in_rt2), .rn(in_rn), .rm(in_rm),
      .size(size_e), .isa(isa_e), .hits(pair_h)
   );

   lsc_overlap_rules #(.REG_W(REG_W)) ovl_i (
      .rt(in_rt), .rt2(in_rt2), .rn(in_rn), .rm(in_rm),
      .size(size_e), .load(in_load), .index(index_e), .legacy(in_legacy),
      .hits(ovl_h)
   );

   lsc_pcsp_rules #(.REG_W(REG_W), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) pcsp_i (
      .rt(in_rt), .rn(in_rn), .rm(in_rm),
      .size(size_e), .load(in_load), .index(index_e), .isa(isa_e),
      .hits(pcsp_h)
   );

   assign any_ill = pair_h.illegal | ovl_h.illegal | pcsp_h.illegal;
   assign any_unp = pair_h.unpred  | ovl_h.unpred  | pcsp_h.unpred;
   assign any_dep = pair_h.deprec  | ovl_h.deprec  | pcsp_h.deprec;
   assign legal_c = !(any_ill || any_unp);

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid         <= 1'b0;
         out_legal         <= 1'b0;
         out_deprecated    <= 1'b0;
         out_unpredictable <= 1'b0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_legal         <= legal_c;
            out_deprecated    <= legal_c && any_dep;
            out_unpredictable <= any_unp;
         end
      end
   end

   AST_OFFSET_NOT_PC: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (in_rm == REG_W'(PC_IDX)) |=> out_valid && !out_legal); // R1
   AST_NARROW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (in_isa == 2'd2) && (in_rn >= REG_W'(LOW_REGS)) |=> !out_legal); // R2
   AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (in_isa == 2'd0) && (in_size == 3'd5) && in_rt[0] |=> !out_legal); // R3
   AST_WIDE_DUAL_SP: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (in_isa != 2'd0) && (in_size == 3'd5) && (in_rt2 == REG_W'(SP_IDX)) |=> !out_legal); // R4
   AST_WB_BASE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (in_index != 2'd0) && (in_rn == in_rt) |=> out_unpredictable); // R5
   AST_DUAL_LOAD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (in_size == 3'd5) && in_load && (in_rm == in_rt2) |=> out_unpredictable); // R6
   AST_COMPACT_PC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (in_isa != 2'd0) && (in_rn == REG_W'(PC_IDX)) |=> !out_legal); // R7
   AST_COMPACT_SP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (in_isa != 2'd0) && (in_rm == REG_W'(SP_IDX)) |=> out_unpredictable); // R8
   AST_DEP_NEEDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_deprecated |-> out_legal); // R10
   AST_LEGAL_NOT_UNP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_legal |-> !out_unpredictable); // R10
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_legal) &&
      $stable(out_deprecated) && $stable(out_unpredictable)); // R11
endmodule

// File: tb/lsc_operand_checker_tb_top.sv
`timescale 1ns/100ps
module lsc_operand_checker_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [3:0] in_rt = '0, in_rt2 = '0, in_rn = '0, in_rm = '0;
   logic [2:0] in_size = '0;
   logic       in_load = 1'b0;
   logic [1:0] in_index = '0, in_isa = '0;
   logic       in_legacy = 1'b0;
   logic       out_valid, out_ready = 1'b1;
   logic       out_legal, out_deprecated, out_unpredictable;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [2:0] exp_q[$];
   string      tag_q[$];
   logic       hold_pending = 1'b0;
   logic [2:0] hold_val = '0;
   logic       done = 1'b0;

   always #2.5 clk = ~clk;

   lsc_operand_checker dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_rt(in_rt), .in_rt2(in_rt2), .in_rn(in_rn), .in_rm(in_rm),
      .in_size(in_size), .in_load(in_load), .in_index(in_index), .in_isa(in_isa),
      .in_legacy(in_legacy), .out_valid(out_valid), .out_ready(out_ready),
      .out_legal(out_legal), .out_deprecated(out_deprecated),
      .out_unpredictable(out_unpredictable)
   );

   // expected {legal, deprecated, unpredictable} from the requirements
   function automatic logic [2:0] model(input logic [3:0] rt, rt2, rn, rm,
                                        input logic [2:0] sz, input logic ld,
                                        input logic [1:0] ix, isa, input logic old);
      logic ill, unp, dep, wb, dual, full, lg;
      ill = 0; unp = 0; dep = 0;
      wb = (ix != 0); dual = (sz == 5); full = (isa == 0);
      if (rm == 15) ill = 1;                                                     // R1
      if (isa == 2 && (rt > 7 || rn > 7 || rm > 7 || dual)) ill = 1;             // R2
      if (full && dual && (rt[0] || rt == 14 || {1'b0, rt2} != {1'b0, rt} + 5'd1)) ill = 1; // R3
      if (!full && dual && (rt == 13 || rt == 15 || rt2 == 13 || rt2 == 15)) ill = 1; // R4
      if (wb && rn == rt) unp = 1;                                               // R5
      if (wb && old && rn == rm) unp = 1;
      if (dual && ld && (rm == rt || rm == rt2)) unp = 1;                        // R6
      if (dual && wb && rn == rt2) unp = 1;
      if (full) begin                                                            // R7, R8
         if (rt == 15 && sz != 0) ill = 1;
         if (rn == 15 && wb) ill = 1;
         if (!ld && rt == 15) dep = 1;
         if (!ld && rn == 15 && !wb) dep = 1;
         if (rm == 13) dep = 1;
         if (rt == 13 && sz != 0) dep = 1;
         if (dual && rt == 12) dep = 1;                                          // R9
      end else begin
         if (rt == 15 && !(ld && sz == 0)) ill = 1;
         if (rn == 15) ill = 1;
         if (rm == 13) unp = 1;
         if (rt == 13 && sz != 0) unp = 1;
      end
      lg = !(ill || unp);                                                        // R10
      return {lg, dep && lg, unp};
   endfunction

   task automatic send(input string tag, input logic [3:0] rt, rt2, rn, rm,
                       input logic [2:0] sz, input logic ld,
                       input logic [1:0] ix, isa, input logic old);
      @(negedge clk);
      in_rt = rt; in_rt2 = rt2; in_rn = rn; in_rm = rm; in_size = sz;
      in_load = ld; in_index = ix; in_isa = isa; in_legacy = old; in_valid = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      exp_q.push_back(model(rt, rt2, rn, rm, sz, ld, ix, isa, old));
      tag_q.push_back(tag);
      @(posedge clk);
   endtask

   always @(negedge clk) cyc <= cyc + 1;

   // consumer: periodic stalls, then scoreboard compare on each transfer
   always @(negedge clk) begin
      if (rst_n) begin
         out_ready = (cyc % 4 != 2);
         #0.5;
         if (hold_pending) begin
            checks++;
            if (!out_valid || {out_legal, out_deprecated, out_unpredictable} != hold_val) begin
               errors++;
               $display("FAIL R11 stall hold act=%b%b%b%b exp=1%b", out_valid,
                        out_legal, out_deprecated, out_unpredictable, hold_val);
            end
            hold_pending = 1'b0;
         end
         if (out_valid && !out_ready) begin
            hold_pending = 1'b1;
            hold_val = {out_legal, out_deprecated, out_unpredictable};
            checks++;
            if (in_ready) begin
               errors++;
               $display("FAIL R11 in_ready while stalled act=1 exp=0");
            end
         end
         if (out_valid && out_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R11 unexpected result act=%b%b%b exp=none",
                        out_legal, out_deprecated, out_unpredictable);
            end else begin
               logic [2:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if ({out_legal, out_deprecated, out_unpredictable} != e) begin
                  errors++;
                  $display("FAIL %s legal/dep/unp act=%b%b%b exp=%b", t,
                           out_legal, out_deprecated, out_unpredictable, e);
               end
            end
         end
      end
   end

   initial begin : watchdog
      #900000;
      errors++;
      checks++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      logic [31:0] lf;
      lf = 32'h1ACE_B00C;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R12 reset out_valid act=%b exp=0", out_valid);
      end
      rst_n = 1'b1;
      // directed cases: (rt, rt2, rn, rm, size, load, index, isa, legacy)
      send("R10", 4'd1, 4'd0, 4'd2, 4'd3, 3'd0, 1, 2'd0, 2'd0, 0);
      send("R1",  4'd1, 4'd0, 4'd2, 4'd15, 3'd0, 1, 2'd0, 2'd0, 0);
      send("R2",  4'd1, 4'd0, 4'd8, 4'd3, 3'd1, 1, 2'd0, 2'd2, 0);
      send("R2",  4'd2, 4'd3, 4'd4, 4'd5, 3'd5, 1, 2'd0, 2'd2, 0);
      send("R3",  4'd3, 4'd4, 4'd8, 4'd9, 3'd5, 1, 2'd0, 2'd0, 0);
      send("R3",  4'd14, 4'd15, 4'd8, 4'd9, 3'd5, 0, 2'd0, 2'd0, 0);
      send("R3",  4'd4, 4'd6, 4'd8, 4'd9, 3'd5, 1, 2'd0, 2'd0, 0);
      send("R10", 4'd4, 4'd5, 4'd8, 4'd9, 3'd5, 1, 2'd1, 2'd0, 0);
      send("R4",  4'd12, 4'd13, 4'd8, 4'd9, 3'd5, 1, 2'd0, 2'd1, 0);
      send("R4",  4'd6, 4'd15, 4'd8, 4'd9, 3'd5, 0, 2'd0, 2'd1, 0);
      send("R5",  4'd3, 4'd0, 4'd3, 4'd5, 3'd0, 1, 2'd1, 2'd0, 0);
      send("R5",  4'd3, 4'd0, 4'd5, 4'd5, 3'd0, 1, 2'd2, 2'd0, 1);
      send("R5",  4'd3, 4'd0, 4'd5, 4'd5, 3'd0, 1, 2'd2, 2'd0, 0);
      send("R6",  4'd4, 4'd5, 4'd8, 4'd5, 3'd5, 1, 2'd0, 2'd0, 0);
      send("R6",  4'd4, 4'd5, 4'd8, 4'd5, 3'd5, 0, 2'd0, 2'd0, 0);
      send("R6",  4'd4, 4'd5, 4'd5, 4'd9, 3'd5, 0, 2'd2, 2'd0, 0);
      send("R7",  4'd15, 4'd0, 4'd2, 4'd3, 3'd3, 1, 2'd0, 2'd0, 0);
      send("R7",  4'd15, 4'd0, 4'd2, 4'd3, 3'd0, 0, 2'd0, 2'd0, 0);
      send("R7",  4'd1, 4'd0, 4'd15, 4'd3, 3'd0, 1, 2'd1, 2'd0, 0);
      send("R7",  4'd1, 4'd0, 4'd15, 4'd3, 3'd0, 0, 2'd0, 2'd0, 0);
      send("R7",  4'd15, 4'd0, 4'd2, 4'd3, 3'd0, 1, 2'd0, 2'd1, 0);
      send("R7",  4'd15, 4'd0, 4'd2, 4'd3, 3'd0, 0, 2'd0, 2'd1, 0);
      send("R7",  4'd1, 4'd0, 4'd15, 4'd3, 3'd0, 1, 2'd0, 2'd1, 0);
      send("R8",  4'd1, 4'd0, 4'd2, 4'd13, 3'd0, 1, 2'd0, 2'd1, 0);
      send("R8",  4'd1, 4'd0, 4'd2, 4'd13, 3'd0, 1, 2'd0, 2'd0, 0);
      send("R8",  4'd13, 4'd0, 4'd2, 4'd3, 3'd3, 1, 2'd0, 2'd1, 0);
      send("R8",  4'd13, 4'd0, 4'd2, 4'd3, 3'd1, 0, 2'd0, 2'd0, 0);
      send("R9",  4'd12, 4'd13, 4'd2, 4'd3, 3'd5, 1, 2'd0, 2'd0, 0);
      send("R10", 4'd12, 4'd13, 4'd2, 4'd15, 3'd5, 1, 2'd0, 2'd0, 0);
      // pseudo-random stream, back to back
      for (int i = 0; i < 400; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         send("R10", lf[3:0], lf[7:4], lf[11:8], lf[15:12], 3'(lf[18:16] % 6),
              lf[19], 2'(lf[23:20] % 3), 2'(lf[27:24] % 3), lf[28]);
      end
      @(negedge clk);
      in_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule